// File: doc/BRIEF.md
# Stage Compare and Re-execution Controller

This controller runs beside the six-stage pipeline of one core in a lockstep pair. In every cycle each stage hands over three things: an occupancy bit, a signature of what it produced, and the program counter and sub-step index of the instruction it holds. The partner core's signature for the same stage arrives on a second port. The controller latches all of this and compares the latched copies in the following cycle. When a valid stage disagrees, it raises a one-cycle mismatch event. The event gives a restart address and a sub-step, plus a mask of the stages to discard. The surrounding pipeline handles it like a mispredicted branch and restarts fetch at the faulty instruction.

Instructions that write more than one register are split into sub-steps. Each sub-step has its own sub-step index, so a restart resumes at the exact sub-step that failed, and a write that already retired is never applied again. The first event of a recovery saves the restart point. Any further mismatch before that point passes write back again sends fetch back to the saved point, and each such event deepens a nesting count. A saturating counter of all events is provided for the logic that picks the redundancy mode.

Top module: `rexec_ctrl`

## Requirements
- R1: After reset, `mismatch_o`, `flush_o`, `in_retry_o`, `retry_nest_o` and `retry_cnt_o` are all zero.
- R2: Suppose a stage is valid in cycle k and its local signature differs from the partner's. Then `mismatch_o` is high in cycle k+2, and `redirect_pc_o` and `mis_stage_o` carry that stage's PC and index. Stage indices are 0 fetch, 1 decode, 2 register read, 3 execute, 4 memory access, 5 write back.
- R3: A stage whose valid bit is low never causes a mismatch, whatever its signatures are. Equal signatures never cause one either.
- R4: When several stages mismatch in the same cycle, the stage with the highest index (the oldest instruction) supplies the restart PC, sub-step and stage index.
- R5: While `mismatch_o` is high, `flush_o` bit i is set exactly for stages 0 through the selected stage index. While it is low, `flush_o` is zero.
- R6: `redirect_spc_o` carries the sub-step index of the failing instruction, so a restart of a second sub-step reports that sub-step and not 0.
- R7: Stage inputs presented in cycle k+1 and in cycle k+2 are ignored after a mismatch detected from cycle k inputs. They never raise another event.
- R8: A mismatch while `in_retry_o` is high redirects to the restart point saved by the first event of the recovery, not to the failing stage's PC. It also increments `retry_nest_o` (saturating). The first event sets `in_retry_o` and sets `retry_nest_o` to 1.
- R9: A recovery ends two cycles after a valid write-back stage with matching signatures presents the saved PC and sub-step, provided no mismatch was detected in that same cycle. At that point `in_retry_o` and `retry_nest_o` return to 0. A write-back with a different PC or sub-step does not end it.
- R10: `retry_cnt_o` increments by one on every event, saturates at its maximum, and changes at no other time.
- R11: `mismatch_o` is high for exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg_vld_i | input | NSTG | Stage occupancy, one bit per stage |
| stg_sig_i | input | NSTG*SIGW | Local stage output signatures, stage i at bits [i*SIGW +: SIGW] |
| peer_sig_i | input | NSTG*SIGW | Partner core stage output signatures, same layout |
| stg_pc_i | input | NSTG*PCW | PC held in each stage |
| stg_spc_i | input | NSTG*SPW | Sub-step index held in each stage |
| mismatch_o | output | 1 | One-cycle event: restart the pipeline |
| redirect_pc_o | output | PCW | Restart PC |
| redirect_spc_o | output | SPW | Restart sub-step |
| flush_o | output | NSTG | Stages to discard |
| mis_stage_o | output | IDXW | Index of the stage that decided the event |
| in_retry_o | output | 1 | A recovery is in progress |
| retry_nest_o | output | NESTW | Events inside the current recovery |
| retry_cnt_o | output | CNTW | Saturating event count |

## Verification
The hardest situation to reach is a second error inside a recovery. The bench has to open a recovery, then let a later instruction reach write back without ending it, and then inject a second disagreement in an unrelated stage. Only then is it visible whether fetch returns to the saved point rather than to that stage's PC. The stimulus does this by hand. It sequences a first mismatch, a write back whose PC is not the saved one, and a mismatch at a different PC. It then ends the recovery with the saved PC and sub-step. Blanking gets the same treatment: new mismatches are presented exactly in the two cycles that follow detection.

// File: rtl/rexec_pkg.sv
package rexec_pkg;
  typedef enum logic [2:0] {
    STG_FETCH  = 3'd0,
    STG_DECODE = 3'd1,
    STG_RDREG  = 3'd2,
    STG_EXEC   = 3'd3,
    STG_MEM    = 3'd4,
    STG_WBACK  = 3'd5
  } stage_e;
  localparam int unsigned STAGE_COUNT = 6;
endpackage

// File: rtl/rexec_stage_cmp.sv
module rexec_stage_cmp #(
  parameter int unsigned PCW  = 16,
  parameter int unsigned SPW  = 2,
  parameter int unsigned SIGW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            kill_i,
  input  logic            vld_i,
  input  logic [SIGW-1:0] sig_i,
  input  logic [SIGW-1:0] peer_i,
  input  logic [PCW-1:0]  pc_i,
  input  logic [SPW-1:0]  spc_i,
  output logic            vld_q_o,
  output logic [PCW-1:0]  pc_q_o,
  output logic [SPW-1:0]  spc_q_o,
  output logic            mis_o
);
  logic            vld_q, vld_d;
  logic            cap_en;
  logic [SIGW-1:0] sig_q, peer_q;
  logic [PCW-1:0]  pc_q;
  logic [SPW-1:0]  spc_q;

  always_comb begin
    vld_d  = vld_i & ~kill_i;
    cap_en = vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q  <= '0;
      peer_q <= '0;
      pc_q   <= '0;
      spc_q  <= '0;
    end else if (cap_en) begin
      sig_q  <= sig_i;
      peer_q <= peer_i;
      pc_q   <= pc_i;
      spc_q  <= spc_i;
    end
  end

  always_comb begin
    vld_q_o = vld_q;
    pc_q_o  = pc_q;
    spc_q_o = spc_q;
    mis_o   = vld_q & (sig_q != peer_q);
  end
endmodule

// File: rtl/rexec_oldest_pick.sv
module rexec_oldest_pick #(
  parameter int unsigned NSTG = 6,
  parameter int unsigned IDXW = 3
) (
  input  logic [NSTG-1:0] mis_i,
  output logic            any_o,
  output logic [IDXW-1:0] idx_o,
  output logic [NSTG-1:0] flush_o
);
  always_comb begin
    any_o = |mis_i;
    idx_o = '0;
    for (int i = 0; i < NSTG; i++) begin
      if (mis_i[i]) idx_o = IDXW'(i);
    end
    for (int j = 0; j < NSTG; j++) begin
      flush_o[j] = any_o & (IDXW'(j) <= idx_o);
    end
  end
endmodule

// File: rtl/rexec_retry_track.sv
module rexec_retry_track #(
  parameter int unsigned NSTG  = 6,
  parameter int unsigned IDXW  = 3,
  parameter int unsigned PCW   = 16,
  parameter int unsigned SPW   = 2,
  parameter int unsigned CNTW  = 8,
  parameter int unsigned NESTW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic [PCW-1:0]   fail_pc_i,
  input  logic [SPW-1:0]   fail_spc_i,
  input  logic [IDXW-1:0]  fail_idx_i,
  input  logic [NSTG-1:0]  fail_flush_i,
  input  logic             wb_vld_i,
  input  logic [PCW-1:0]   wb_pc_i,
  input  logic [SPW-1:0]   wb_spc_i,
  output logic             redir_o,
  output logic [PCW-1:0]   redir_pc_o,
  output logic [SPW-1:0]   redir_spc_o,
  output logic [NSTG-1:0]  flush_o,
  output logic [IDXW-1:0]  stage_o,
  output logic             in_retry_o,
  output logic [NESTW-1:0] nest_o,
  output logic [CNTW-1:0]  cnt_o
);
  localparam logic [CNTW-1:0]  CNT_MAX  = {CNTW{1'b1}};
  localparam logic [NESTW-1:0] NEST_MAX = {NESTW{1'b1}};

  logic             redir_q, redir_d;
  logic [PCW-1:0]   rpc_q, rpc_d, snap_pc_q, snap_pc_d;
  logic [SPW-1:0]   rspc_q, rspc_d, snap_spc_q, snap_spc_d;
  logic [NSTG-1:0]  flush_q, flush_d;
  logic [IDXW-1:0]  stage_q, stage_d;
  logic             retry_q, retry_d;
  logic [NESTW-1:0] nest_q, nest_d;
  logic [CNTW-1:0]  cnt_q, cnt_d;
  logic             done;
  logic             out_en;

  always_comb begin
    done       = retry_q & wb_vld_i & ~evt_i &
                 (wb_pc_i == snap_pc_q) & (wb_spc_i == snap_spc_q);
    out_en     = evt_i | redir_q;
    redir_d    = evt_i;
    rpc_d      = rpc_q;
    rspc_d     = rspc_q;
    stage_d    = stage_q;
    flush_d    = '0;
    snap_pc_d  = snap_pc_q;
    snap_spc_d = snap_spc_q;
    retry_d    = retry_q;
    nest_d     = nest_q;
    cnt_d      = cnt_q;
    if (evt_i) begin
      flush_d = fail_flush_i;
      stage_d = fail_idx_i;
      cnt_d   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      if (retry_q) begin
        rpc_d  = snap_pc_q;
        rspc_d = snap_spc_q;
        nest_d = (nest_q == NEST_MAX) ? nest_q : nest_q + 1'b1;
      end else begin
        rpc_d      = fail_pc_i;
        rspc_d     = fail_spc_i;
        snap_pc_d  = fail_pc_i;
        snap_spc_d = fail_spc_i;
        retry_d    = 1'b1;
        nest_d     = NESTW'(1);
      end
    end else if (done) begin
      retry_d = 1'b0;
      nest_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_q <= 1'b0;
      flush_q <= '0;
      retry_q <= 1'b0;
      nest_q  <= '0;
      cnt_q   <= '0;
    end else begin
      redir_q <= redir_d;
      flush_q <= flush_d;
      retry_q <= retry_d;
      nest_q  <= nest_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpc_q      <= '0;
      rspc_q     <= '0;
      stage_q    <= '0;
      snap_pc_q  <= '0;
      snap_spc_q <= '0;
    end else if (out_en) begin
      rpc_q      <= rpc_d;
      rspc_q     <= rspc_d;
      stage_q    <= stage_d;
      snap_pc_q  <= snap_pc_d;
      snap_spc_q <= snap_spc_d;
    end
  end

  always_comb begin
    redir_o     = redir_q;
    redir_pc_o  = rpc_q;
    redir_spc_o = rspc_q;
    flush_o     = flush_q;
    stage_o     = stage_q;
    in_retry_o  = retry_q;
    nest_o      = nest_q;
    cnt_o       = cnt_q;
  end
endmodule

// File: rtl/rexec_ctrl.sv
module rexec_ctrl #(
  parameter int unsigned NSTG  = rexec_pkg::STAGE_COUNT,
  parameter int unsigned PCW   = 16,
  parameter int unsigned SPW   = 2,
  parameter int unsigned SIGW  = 16,
  parameter int unsigned CNTW  = 8,
  parameter int unsigned NESTW = 3,
  localparam int unsigned IDXW = $clog2(NSTG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSTG-1:0]      stg_vld_i,
  input  logic [NSTG*SIGW-1:0] stg_sig_i,
  input  logic [NSTG*SIGW-1:0] peer_sig_i,
  input  logic [NSTG*PCW-1:0]  stg_pc_i,
  input  logic [NSTG*SPW-1:0]  stg_spc_i,
  output logic                 mismatch_o,
  output logic [PCW-1:0]       redirect_pc_o,
  output logic [SPW-1:0]       redirect_spc_o,
  output logic [NSTG-1:0]      flush_o,
  output logic [IDXW-1:0]      mis_stage_o,
  output logic                 in_retry_o,
  output logic [NESTW-1:0]     retry_nest_o,
  output logic [CNTW-1:0]      retry_cnt_o
);
  localparam int unsigned WB_IDX = NSTG - 1;

  logic [NSTG-1:0] cap_vld;
  logic [NSTG-1:0] cap_mis;
  logic [PCW-1:0]  cap_pc  [NSTG];
  logic [SPW-1:0]  cap_spc [NSTG];
  logic            any_mis;
  logic [IDXW-1:0] sel_idx;
  logic [NSTG-1:0] sel_flush;
  logic            kill;
  logic            redir;
  logic [PCW-1:0]  sel_pc;
  logic [SPW-1:0]  sel_spc;

  always_comb kill = any_mis | redir;

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    rexec_stage_cmp #(.PCW(PCW), .SPW(SPW), .SIGW(SIGW)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .kill_i  (kill),
      .vld_i   (stg_vld_i[g]),
      .sig_i   (stg_sig_i[g*SIGW +: SIGW]),
      .peer_i  (peer_sig_i[g*SIGW +: SIGW]),
      .pc_i    (stg_pc_i[g*PCW +: PCW]),
      .spc_i   (stg_spc_i[g*SPW +: SPW]),
      .vld_q_o (cap_vld[g]),
      .pc_q_o  (cap_pc[g]),
      .spc_q_o (cap_spc[g]),
      .mis_o   (cap_mis[g])
    );
  end

  rexec_oldest_pick #(.NSTG(NSTG), .IDXW(IDXW)) u_pick (
    .mis_i   (cap_mis),
    .any_o   (any_mis),
    .idx_o   (sel_idx),
    .flush_o (sel_flush)
  );

  always_comb begin
    sel_pc  = '0;
    sel_spc = '0;
    for (int i = 0; i < NSTG; i++) begin
      if (IDXW'(i) == sel_idx) begin
        sel_pc  = cap_pc[i];
        sel_spc = cap_spc[i];
      end
    end
  end

  rexec_retry_track #(
    .NSTG(NSTG), .IDXW(IDXW), .PCW(PCW), .SPW(SPW), .CNTW(CNTW), .NESTW(NESTW)
  ) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (any_mis),
    .fail_pc_i    (sel_pc),
    .fail_spc_i   (sel_spc),
    .fail_idx_i   (sel_idx),
    .fail_flush_i (sel_flush),
    .wb_vld_i     (cap_vld[WB_IDX]),
    .wb_pc_i      (cap_pc[WB_IDX]),
    .wb_spc_i     (cap_spc[WB_IDX]),
    .redir_o      (redir),
    .redir_pc_o   (redirect_pc_o),
    .redir_spc_o  (redirect_spc_o),
    .flush_o      (flush_o),
    .stage_o      (mis_stage_o),
    .in_retry_o   (in_retry_o),
    .nest_o       (retry_nest_o),
    .cnt_o        (retry_cnt_o)
  );

  always_comb mismatch_o = redir;
endmodule

// File: rtl/rexec_ctrl_chk.sv
module rexec_ctrl_chk #(
  parameter int unsigned NSTG  = 6,
  parameter int unsigned CNTW  = 8,
  parameter int unsigned NESTW = 3,
  parameter int unsigned IDXW  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mismatch_o,
  input logic [NSTG-1:0]  flush_o,
  input logic [IDXW-1:0]  mis_stage_o,
  input logic             in_retry_o,
  input logic [NESTW-1:0] retry_nest_o,
  input logic [CNTW-1:0]  retry_cnt_o
);
  p_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_o |=> !mismatch_o);

  p_flush_span_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_o |-> (flush_o[0] && flush_o[mis_stage_o]));

  p_flush_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mismatch_o |-> (flush_o == '0));

  p_cnt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mismatch_o |-> $stable(retry_cnt_o));

  p_event_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_o |-> (in_retry_o && retry_nest_o != '0));

  p_clean_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_retry_o) |-> (!mismatch_o && retry_nest_o == '0));

  p_nest_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch_o && $past(in_retry_o) && ($past(retry_nest_o) != {NESTW{1'b1}}))
      |-> (retry_nest_o == $past(retry_nest_o) + 1'b1));
endmodule

bind rexec_ctrl rexec_ctrl_chk #(
  .NSTG(NSTG), .CNTW(CNTW), .NESTW(NESTW), .IDXW(IDXW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mismatch_o   (mismatch_o),
  .flush_o      (flush_o),
  .mis_stage_o  (mis_stage_o),
  .in_retry_o   (in_retry_o),
  .retry_nest_o (retry_nest_o),
  .retry_cnt_o  (retry_cnt_o)
);

// File: tb/rexec_ctrl_tb.sv
module rexec_ctrl_tb;
  localparam int NSTG = 6, PCW = 16, SPW = 2, SIGW = 16, CNTW = 8, NESTW = 3, IDXW = 3;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NSTG-1:0]      vld = '0;
  logic [NSTG*SIGW-1:0] lsig = '0;
  logic [NSTG*SIGW-1:0] psig = '0;
  logic [NSTG*PCW-1:0]  pcs = '0;
  logic [NSTG*SPW-1:0]  spcs = '0;
  logic                 mis;
  logic [PCW-1:0]       rpc;
  logic [SPW-1:0]       rspc;
  logic [NSTG-1:0]      flush;
  logic [IDXW-1:0]      mstg;
  logic                 inr;
  logic [NESTW-1:0]     nest;
  logic [CNTW-1:0]      cnt;

  int errors = 0;
  int checks = 0;
  int exp_cnt = 0;

  always #2 clk = ~clk;

  rexec_ctrl #(.NSTG(NSTG), .PCW(PCW), .SPW(SPW), .SIGW(SIGW), .CNTW(CNTW), .NESTW(NESTW)) u_dut (
    .clk(clk), .rst_n(rst_n), .stg_vld_i(vld), .stg_sig_i(lsig), .peer_sig_i(psig),
    .stg_pc_i(pcs), .stg_spc_i(spcs), .mismatch_o(mis), .redirect_pc_o(rpc),
    .redirect_spc_o(rspc), .flush_o(flush), .mis_stage_o(mstg), .in_retry_o(inr),
    .retry_nest_o(nest), .retry_cnt_o(cnt)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic clear_in();
    vld = '0; lsig = '0; psig = '0; pcs = '0; spcs = '0;
  endtask

  task automatic put(input int s, input int pc, input int spc, input bit bad);
    vld[s] = 1'b1;
    lsig[s*SIGW +: SIGW] = SIGW'(16'h5A00 + s);
    psig[s*SIGW +: SIGW] = bad ? SIGW'(16'h5A80 + s) : SIGW'(16'h5A00 + s);
    pcs[s*PCW +: PCW] = PCW'(pc);
    spcs[s*SPW +: SPW] = SPW'(spc);
  endtask

  // present current inputs for one cycle, then idle; returns at the negedge after outputs update
  task automatic pulse_and_wait();
    @(negedge clk); clear_in();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_retry(input string req, input int pc, input int spc);
    clear_in(); put(5, pc, spc, 1'b0);
    pulse_and_wait();
    check(req, "retry closed", inr, 0);
    check(req, "nest cleared", nest, 0);
    idle(2);
  endtask

  task automatic t_reset();
    check("R1", "mismatch", mis, 0);
    check("R1", "flush", flush, 0);
    check("R1", "in_retry", inr, 0);
    check("R1", "nest", nest, 0);
    check("R1", "count", cnt, 0);
  endtask

  task automatic t_basic();
    clear_in(); put(3, 16'h0123, 0, 1'b1);
    pulse_and_wait();
    exp_cnt++;
    check("R2", "event", mis, 1);
    check("R2", "pc", rpc, 16'h0123);
    check("R2", "stage", mstg, 3);
    check("R5", "flush mask", flush, 6'b001111);
    check("R8", "first opens", inr, 1);
    check("R8", "first nest", nest, 1);
    check("R10", "count", cnt, exp_cnt);
    @(negedge clk);
    check("R11", "pulse drops", mis, 0);
    check("R5", "flush idle", flush, 0);
    idle(1);
    finish_retry("R9", 16'h0123, 0);
  endtask

  task automatic t_invalid();
    clear_in();
    lsig = {NSTG{16'hAAAA}}; psig = {NSTG{16'h5555}};
    @(negedge clk); @(negedge clk);
    check("R3", "invalid stages", mis, 0);
    clear_in();
    for (int s = 0; s < NSTG; s++) put(s, 16'h0200 + s, 0, 1'b0);
    pulse_and_wait();
    check("R3", "equal signatures", mis, 0);
    check("R3", "count unchanged", cnt, exp_cnt);
  endtask

  task automatic t_oldest();
    clear_in(); put(1, 16'h0011, 0, 1'b1); put(4, 16'h0044, 2, 1'b1);
    pulse_and_wait();
    exp_cnt++;
    check("R4", "event", mis, 1);
    check("R4", "oldest pc", rpc, 16'h0044);
    check("R4", "oldest stage", mstg, 4);
    check("R4", "oldest sub-step", rspc, 2);
    check("R5", "flush mask", flush, 6'b011111);
    idle(2);
    finish_retry("R9", 16'h0044, 2);
  endtask

  task automatic t_substep();
    clear_in(); put(4, 16'h0080, 1, 1'b1);
    pulse_and_wait();
    exp_cnt++;
    check("R6", "pc", rpc, 16'h0080);
    check("R6", "sub-step", rspc, 1);
    idle(2);
    clear_in(); put(5, 16'h0080, 0, 1'b0);
    pulse_and_wait();
    check("R9", "other sub-step keeps retry", inr, 1);
    idle(1);
    finish_retry("R9", 16'h0080, 1);
  endtask

  task automatic t_blank();
    clear_in(); put(2, 16'h0300, 0, 1'b1);
    @(negedge clk); clear_in(); put(5, 16'h0999, 0, 1'b1);
    @(negedge clk);
    exp_cnt++;
    check("R7", "first event", mis, 1);
    check("R7", "first pc", rpc, 16'h0300);
    clear_in(); put(0, 16'h0999, 0, 1'b1);
    @(negedge clk); clear_in();
    check("R7", "no second event", mis, 0);
    @(negedge clk);
    check("R7", "still no event", mis, 0);
    @(negedge clk);
    check("R7", "count", cnt, exp_cnt);
    finish_retry("R9", 16'h0300, 0);
  endtask

  task automatic t_nested();
    clear_in(); put(2, 16'h0100, 0, 1'b1);
    pulse_and_wait();
    exp_cnt++;
    idle(2);
    clear_in(); put(5, 16'h0200, 0, 1'b0);
    pulse_and_wait();
    check("R9", "foreign pc keeps retry", inr, 1);
    clear_in(); put(4, 16'h0200, 3, 1'b1);
    pulse_and_wait();
    exp_cnt++;
    check("R8", "nested event", mis, 1);
    check("R8", "back to snapshot pc", rpc, 16'h0100);
    check("R8", "back to snapshot sub-step", rspc, 0);
    check("R8", "nest depth", nest, 2);
    check("R8", "stage reported", mstg, 4);
    idle(2);
    finish_retry("R9", 16'h0100, 0);
  endtask

  task automatic t_saturate();
    while (exp_cnt < 255) begin
      clear_in(); put(0, 16'h0400, 0, 1'b1);
      pulse_and_wait();
      exp_cnt++;
      idle(2);
    end
    check("R10", "reached max", cnt, 255);
    check("R8", "nest saturated", nest, 7);
    clear_in(); put(0, 16'h0400, 0, 1'b1);
    pulse_and_wait();
    check("R10", "event at max", mis, 1);
    check("R10", "saturated", cnt, 255);
    idle(2);
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clear_in();
    idle(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    t_reset();
    t_basic();
    t_invalid();
    t_oldest();
    t_substep();
    t_blank();
    t_nested();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule